// File: doc/BRIEF.md
# Narrow-access to word-only register bridge

This bridge sits between a host that issues 8-, 16- and 32-bit register reads and writes and a peripheral register port that accepts only aligned 32-bit accesses. A narrow read becomes one word read, after which the selected byte or half-word lane is shifted down and zero-extended. A narrow write becomes a read-modify-write of the containing word: the word is read, the selected lane is replaced, and the merged word is written back. Full-word writes go straight through.

One pair of half-words needs special handling. The lower half of the word at `XFER_OFF` is the transfer-mode field and the upper half is the command field. A 16-bit write to the transfer-mode half does not go downstream; its merged word is kept in a shadow register. A later 16-bit write to the command half uses that shadow word as the old value and sends both halves out in a single word write. Every downstream write is held back until `GAP_CYC` system clocks have passed since the previous one. This protects a peripheral that loses writes arriving too close together across its clock crossing. The default spacing is 6 µs at 250 MHz, which is 1500 cycles.

The host handshake is request/ready. The host may hold only one transaction at a time. `done_o` pulses for one cycle when a transaction completes, and `rdata_o` is valid in that same cycle for reads.

Top module: `narrow_word_bridge`

## Requirements
- R1: Every downstream read or write uses the host address with bits [1:0] cleared.
- R2: A host read produces exactly one downstream read. The size code is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. For 8-bit reads the lane is addr[1:0]×8, and for 16-bit reads the lane is addr[1]×16. `rdata_o` holds that lane zero-extended.
- R3: A narrow write, other than the two special half-words, issues one downstream read and then one downstream write. The write carries the old word with only the addressed lane replaced.
- R4: A 32-bit write issues no downstream read and exactly one downstream write of the host data.
- R5: A 16-bit write with addr[1]=0 to the word at `XFER_OFF` (default 0x0C) issues one downstream read and no downstream write. It stores the old word with its lower half replaced into the shadow.
- R6: A 16-bit write with addr[1]=1 to that same word (default 0x0E) issues no downstream read. It issues one downstream write whose lower half comes from the shadow and whose upper half is the new value.
- R7: Two downstream writes are never closer than `GAP_CYC` cycles apart, so none is lost by a peripheral that drops writes inside that window.
- R8: `ready_o` is low from the cycle after a request is accepted until the transaction completes. `done_o` is a one-cycle pulse.
- R9: A read's `done_o` rises two clock edges after the accepting edge. A 32-bit write made with the spacing window already expired completes one edge after acceptance.
- R10: After reset `ready_o` is high, `done_o`, `dn_rd_o` and `dn_wr_o` are low, and the shadow holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request, accepted when ready_o is high |
| ready_o | output | 1 | Bridge idle and able to accept a request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit |
| addr_i | input | AW | Host byte address |
| wdata_i | input | DW | Write data, right-aligned for narrow writes |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Read result, zero-extended lane |
| dn_rd_o | output | 1 | Downstream word read strobe |
| dn_wr_o | output | 1 | Downstream word write strobe |
| dn_addr_o | output | AW | Downstream word-aligned address |
| dn_wdata_o | output | DW | Downstream write word |
| dn_rdata_i | input | DW | Downstream read word, valid the cycle after dn_rd_o |

## Verification
A read completes two edges after the accepting edge: one edge issues the downstream read and one captures the word. A read-modify-write adds one more edge and then waits out the spacing window. A 32-bit or command write on an idle timer completes in one edge. The bench drives inputs and samples outputs on falling edges, counts rising edges from acceptance to the `done_o` pulse, and checks that count for reads and for a 32-bit write made after a long idle period. After every write it compares the peripheral model's word with the reference, and it compares the number of downstream reads and writes the transaction caused against its category. The peripheral model drops writes inside the spacing window, so a lost write shows up both in the word compare and in a final lost-write count.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CAP  = 2'd2,
    ST_WR   = 2'd3
  } nwb_st_e;
endpackage

// File: rtl/nwb_lane.sv
module nwb_lane import nwb_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word_i,
  input  logic [DW-1:0] new_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    off_i,
  output logic [DW-1:0] lane_o,
  output logic [DW-1:0] merged_o
);
  localparam int SW = $clog2(DW);

  logic [SW-1:0] sh;
  logic [DW-1:0] fld;

  always_comb begin
    case (size_i)
      SZ_B: begin
        sh  = SW'({off_i, 3'b000});
        fld = DW'(8'hff);
      end
      SZ_H: begin
        sh  = SW'({off_i[1], 4'b0000});
        fld = DW'(16'hffff);
      end
      default: begin
        sh  = '0;
        fld = '1;
      end
    endcase
    lane_o   = (word_i >> sh) & fld;
    merged_o = (word_i & ~(fld << sh)) | ((new_i & fld) << sh);
  end
endmodule

// File: rtl/nwb_gap.sv
module nwb_gap #(
  parameter int GAP = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic ok_o
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q;

  // reload on each issued write, count down to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (fire_i)          cnt_q <= CW'(GAP - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q == '0);

  // R7
  gap_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && GAP > 1) |=> !ok_o);
endmodule

// File: rtl/nwb_shadow.sv
module nwb_shadow #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/narrow_word_bridge.sv
module narrow_word_bridge import nwb_pkg::*; #(
  parameter int             AW       = 8,
  parameter int             DW       = 32,
  parameter int             CLK_MHZ  = 250,
  parameter int             GAP_NS   = 6000,
  parameter logic [AW-1:0]  XFER_OFF = 8'h0c
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          dn_rd_o,
  output logic          dn_wr_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [DW-1:0] dn_wdata_o,
  input  logic [DW-1:0] dn_rdata_i
);
  localparam int            GAP_CYC = (CLK_MHZ * GAP_NS) / 1000;
  localparam int            HW      = DW / 2;
  localparam logic [AW-1:0] CMD_OFF = XFER_OFF + AW'(2);
  localparam int            SCW     = $clog2(GAP_CYC + 1);

  nwb_st_e       st_q;
  logic [AW-1:0] a_q;
  logic [1:0]    sz_q;
  logic          we_q;
  logic          to_sh_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] buf_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  logic          acc;
  logic          hit_pair;
  logic          is_cmd;
  logic          is_xfer;
  logic          gap_ok;
  logic          sh_ld;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] lane;
  logic [DW-1:0] merged;

  assign acc      = req_i && (st_q == ST_IDLE);
  assign hit_pair = (size_i == SZ_H) && (addr_i[AW-1:2] == XFER_OFF[AW-1:2]);
  assign is_cmd   = hit_pair && addr_i[1];
  assign is_xfer  = hit_pair && !addr_i[1];
  assign sh_ld    = (st_q == ST_CAP) && we_q && to_sh_q;

  nwb_lane #(.DW(DW)) u_lane (
    .word_i  (dn_rdata_i),
    .new_i   (wd_q),
    .size_i  (sz_q),
    .off_i   (a_q[1:0]),
    .lane_o  (lane),
    .merged_o(merged)
  );

  nwb_gap #(.GAP(GAP_CYC)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(dn_wr_o),
    .ok_o  (gap_ok)
  );

  nwb_shadow #(.DW(DW)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (sh_ld),
    .d_i   (merged),
    .q_o   (sh_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      a_q     <= '0;
      sz_q    <= SZ_W;
      we_q    <= 1'b0;
      to_sh_q <= 1'b0;
      wd_q    <= '0;
      buf_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (acc) begin
          a_q     <= addr_i;
          sz_q    <= size_i;
          we_q    <= we_i;
          wd_q    <= wdata_i;
          to_sh_q <= we_i && is_xfer;
          if (!we_i) begin
            st_q <= ST_RD;
          end else if (size_i == SZ_W) begin
            buf_q <= wdata_i;
            st_q  <= ST_WR;
          end else if (is_cmd) begin
            // command half pairs with the shadowed transfer-mode half
            buf_q <= {wdata_i[HW-1:0], sh_q[HW-1:0]};
            st_q  <= ST_WR;
          end else begin
            st_q <= ST_RD;
          end
        end
        ST_RD: st_q <= ST_CAP;
        ST_CAP: begin
          if (!we_q) begin
            rdata_q <= lane;
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else if (to_sh_q) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            buf_q <= merged;
            st_q  <= ST_WR;
          end
        end
        ST_WR: if (gap_ok) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (st_q == ST_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign dn_rd_o    = (st_q == ST_RD);
  assign dn_wr_o    = (st_q == ST_WR) && gap_ok;
  assign dn_addr_o  = {a_q[AW-1:2], 2'b00};
  assign dn_wdata_o = buf_q;

  // independent spacing monitor
  logic [SCW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_q <= SCW'(GAP_CYC);
    else if (dn_wr_o)                     since_q <= SCW'(1);
    else if (since_q != SCW'(GAP_CYC))    since_q <= since_q + 1'b1;
  end

  // R7
  wr_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_wr_o |-> (since_q >= SCW'(GAP_CYC)));

  // R8
  busy_after_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  single_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_rd_o |=> (!dn_rd_o && !dn_wr_o));

  // R6
  cmd_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && we_i && size_i == SZ_H && addr_i[AW-1:1] == CMD_OFF[AW-1:1])
      |=> !dn_rd_o);

  // R5
  xfer_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && we_i && size_i == SZ_H && addr_i[AW-1:1] == XFER_OFF[AW-1:1])
      |=> dn_rd_o);
endmodule

// File: tb/sim_narrow_word_bridge.sv
module sim_narrow_word_bridge;
  localparam int GAP = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sz = 2'd0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ready_o, done_o, dn_rd_o, dn_wr_o;
  logic [31:0] rdata_o, dn_wdata_o, rdq;
  logic [7:0]  dn_addr_o;

  always #2 clk = ~clk;

  narrow_word_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready_o),
    .we_i(we), .size_i(sz), .addr_i(addr), .wdata_i(wdata),
    .done_o(done_o), .rdata_o(rdata_o), .dn_rd_o(dn_rd_o), .dn_wr_o(dn_wr_o),
    .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o), .dn_rdata_i(rdq)
  );

  // peripheral model: word-only, drops writes inside the spacing window
  logic [31:0] pmem [16];
  int cyc = 0, last_wr = 0, rd_cnt = 0, wr_cnt = 0, lost = 0, misal = 0, min_gap = 1000000;
  logic wr_seen = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pmem[i] <= 32'h1357_9bdf * (i + 1) ^ 32'ha5a5_5a5a;
      rdq <= '0;
    end else begin
      if (dn_rd_o) begin
        rdq    <= pmem[dn_addr_o[5:2]];
        rd_cnt <= rd_cnt + 1;
        if (dn_addr_o[1:0] != 2'b00) misal <= misal + 1;
      end
      if (dn_wr_o) begin
        if (wr_seen && (cyc - last_wr) < min_gap) min_gap <= cyc - last_wr;
        if (wr_seen && (cyc - last_wr) < GAP) lost <= lost + 1;
        else pmem[dn_addr_o[5:2]] <= dn_wdata_o;
        last_wr <= cyc;
        wr_seen <= 1'b1;
        wr_cnt  <= wr_cnt + 1;
        if (dn_addr_o[1:0] != 2'b00) misal <= misal + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [31:0] ref_mem [16];
  logic [31:0] sh_m;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] f_get(input logic [31:0] w, input logic [1:0] s, input logic [7:0] a);
    if (s == 2'd0) return {24'b0, w[a[1:0]*8 +: 8]};
    if (s == 2'd1) return {16'b0, w[a[1]*16 +: 16]};
    return w;
  endfunction

  function automatic logic [31:0] f_put(input logic [31:0] w, input logic [31:0] d, input logic [1:0] s, input logic [7:0] a);
    logic [31:0] r = w;
    if (s == 2'd0) r[a[1:0]*8 +: 8] = d[7:0];
    else if (s == 2'd1) r[a[1]*16 +: 16] = d[15:0];
    else r = d;
    return r;
  endfunction

  task automatic op(input logic w, input logic [1:0] s, input logic [7:0] a, input logic [31:0] d,
                    output logic [31:0] r, output int lat);
    int t0, guard;
    @(negedge clk);
    guard = 0;
    while (!ready_o && guard < 5000) begin @(negedge clk); guard++; end
    req = 1'b1; we = w; sz = s; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    t0 = cyc;
    guard = 0;
    while (!done_o && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) chk(1'b0, "R8 done timeout", 32'(guard), 32'd0);
    r = rdata_o;
    lat = cyc - t0;
  endtask

  // run one op, update reference, check result and downstream access counts
  task automatic run(input logic w, input logic [1:0] s, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    int lat, rd0, wr0, erd, ewr;
    logic [3:0] ix = a[5:2];
    bit pair = (s == 2'd1) && (ix == 4'd3);
    string rq;
    rd0 = rd_cnt; wr0 = wr_cnt;
    op(w, s, a, d, r, lat);
    if (!w) begin
      chk(r == f_get(ref_mem[ix], s, a), "R2 read lane", r, f_get(ref_mem[ix], s, a));
      chk(lat == 2, "R9 read latency", 32'(lat), 32'd2);
      erd = 1; ewr = 0; rq = "R2 counts";
    end else if (s == 2'd2) begin
      ref_mem[ix] = d; erd = 0; ewr = 1; rq = "R4 counts";
    end else if (pair && a[1]) begin
      ref_mem[ix] = f_put(sh_m, d, s, a); erd = 0; ewr = 1; rq = "R6 counts";
    end else if (pair) begin
      sh_m = f_put(ref_mem[ix], d, s, a); erd = 1; ewr = 0; rq = "R5 counts";
    end else begin
      ref_mem[ix] = f_put(ref_mem[ix], d, s, a); erd = 1; ewr = 1; rq = "R3 counts";
    end
    chk(rd_cnt - rd0 == erd, rq, 32'(rd_cnt - rd0), 32'(erd));
    chk(wr_cnt - wr0 == ewr, rq, 32'(wr_cnt - wr0), 32'(ewr));
    if (w) chk(pmem[ix] == ref_mem[ix], "R3 R6 R7 word after write", pmem[ix], ref_mem[ix]);
  endtask

  initial begin
    logic [31:0] r;
    int lat;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) ref_mem[i] = 32'h1357_9bdf * (i + 1) ^ 32'ha5a5_5a5a;
    sh_m = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(ready_o == 1'b1, "R10 ready", 32'(ready_o), 32'd1);
    chk(done_o == 1'b0, "R10 done", 32'(done_o), 32'd0);
    chk(dn_rd_o == 1'b0 && dn_wr_o == 1'b0, "R10 strobes", {30'b0, dn_rd_o, dn_wr_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 shadow zero: command write right after reset
    run(1'b1, 2'd1, 8'h0e, 32'h0000_abcd);
    chk(pmem[3] == 32'habcd_0000, "R10 shadow zero", pmem[3], 32'habcd_0000);
    // R5 R6 pairing
    run(1'b1, 2'd1, 8'h0c, 32'h0000_1234);
    chk(pmem[3] == 32'habcd_0000, "R5 no write yet", pmem[3], 32'habcd_0000);
    run(1'b1, 2'd1, 8'h0e, 32'h0000_5678);
    chk(pmem[3] == 32'h5678_1234, "R6 paired word", pmem[3], 32'h5678_1234);
    // R2 every byte and half lane
    for (int k = 0; k < 4; k++) run(1'b0, 2'd0, 8'(16 + k), 32'd0);
    for (int k = 0; k < 2; k++) run(1'b0, 2'd1, 8'(16 + 2 * k), 32'd0);
    run(1'b0, 2'd2, 8'h13, 32'd0);
    // R3 byte writes to each lane, back to back (R7 spacing)
    for (int k = 0; k < 4; k++) run(1'b1, 2'd0, 8'(20 + k), 32'(8'h11 * (k + 1)));
    // R9 word write on expired window
    repeat (GAP + 10) @(negedge clk);
    op(1'b1, 2'd2, 8'h20, 32'hcafe_f00d, r, lat);
    ref_mem[8] = 32'hcafe_f00d;
    chk(lat == 1, "R9 word write latency", 32'(lat), 32'd1);
    chk(pmem[8] == 32'hcafe_f00d, "R4 word passthrough", pmem[8], 32'hcafe_f00d);
    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] s = 2'($urandom % 3);
      logic [7:0] a = 8'($urandom % 32);
      logic w = 1'($urandom % 2);
      if ($urandom % 4 == 0) begin s = 2'd1; a = 8'h0c | 8'($urandom % 4); end
      run(w, s, a, $urandom);
    end
    chk(lost == 0, "R7 lost writes", 32'(lost), 32'd0);
    chk(min_gap >= GAP, "R7 min gap", 32'(min_gap), 32'(GAP));
    chk(misal == 0, "R1 aligned address", 32'(misal), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule